// File: doc/BRIEF.md
# Segment Tag Store for an In-DRAM Fast Region

This block is the per-bank metadata store that a memory controller keeps for the fast region of a DRAM bank. Each entry records one cached row-segment: whether it is present, whether it has been written since it was brought in, which slow-region row and segment it came from, and a small usage score. A lookup compares the requested row and segment against every entry at once. The index of the matching entry is the fast-region slot where the segment lives.

The controller inserts an entry after moving a segment into the fast region. It can rewrite an entry's dirty flag and score through the update port. Before it reuses a slot it invalidates the old entry, and it receives that entry's dirty flag so it can decide whether the data must be copied back. Every score is exposed in parallel so that a victim selector can pick the slot to reuse. Each hit raises the hit entry's score, which stops at its maximum. A write hit marks the entry dirty.

Top module: `seg_tag_store`

## Requirements
- R1: After reset every entry is invalid with a score of 0, `rsp_valid` and `inv_rsp_valid` are low, and a lookup of any tag, including row 0 segment 0, misses.
- R2: A lookup presented on `lk_req` in cycle N gives `rsp_valid` high in cycle N+1 and low otherwise. `rsp_hit` is high only when a valid entry holds the tag {row, segment}. A different row or a different segment misses.
- R3: On a hit, `rsp_idx` is the index of the matching entry. If several valid entries hold the same tag, the lowest index is reported.
- R4: Each lookup hit adds 1 to that entry's 5-bit score. The score saturates at 31 and does not wrap. The scores of other entries do not change.
- R5: A hit with `lk_write` high marks the entry dirty. A hit with `lk_write` low leaves the dirty flag unchanged.
- R6: An insert at `ins_idx` makes the entry valid with the new tag, dirty clear and a score of 1.
- R7: An update at `upd_idx` writes the entry's dirty flag and score to the values given.
- R8: An invalidate at `inv_idx` in cycle N gives `inv_rsp_valid` in cycle N+1, with `inv_rsp_dirty` equal to the entry's dirty flag before the clear. Later lookups of that tag miss.
- R9: When several operations hit the same index in one cycle, invalidate wins over insert, insert wins over update, and update wins over the side effects of a lookup hit. A lookup sees only the contents as they stood before that cycle.
- R10: `benefit_all` carries the score of entry i in bits [5*i+4 : 5*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_row | input | 15 | Row number to look up |
| lk_seg | input | 4 | Segment ID to look up |
| lk_write | input | 1 | Lookup is a write access |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_idx | output | log2(ENTRIES) | Index of the hit entry |
| ins_req | input | 1 | Insert request |
| ins_idx | input | log2(ENTRIES) | Entry to write |
| ins_row | input | 15 | Row number of the new entry |
| ins_seg | input | 4 | Segment ID of the new entry |
| upd_req | input | 1 | Update request |
| upd_idx | input | log2(ENTRIES) | Entry to update |
| upd_dirty | input | 1 | New dirty flag |
| upd_benefit | input | 5 | New score |
| inv_req | input | 1 | Invalidate request |
| inv_idx | input | log2(ENTRIES) | Entry to invalidate |
| inv_rsp_valid | output | 1 | Invalidate result valid |
| inv_rsp_dirty | output | 1 | Dirty flag of the invalidated entry |
| benefit_all | output | 5*ENTRIES | All scores, entry i at bits [5*i+4 : 5*i] |

## Verification
A stale valid flag or tag inside the store shows at the ports one cycle after the next lookup of that tag, as a wrong hit, a wrong miss or a wrong index. A bad score is visible on `benefit_all` in the cycle after the insert, hit or update that produced it. A bad dirty flag stays hidden until the entry is invalidated, and then shows one cycle later on `inv_rsp_dirty`. Because of this, the sweeps end each scenario by invalidating the entries involved.

// File: rtl/seg_tag_pkg.sv
package seg_tag_pkg;
    localparam int ROW_W   = 15;
    localparam int SEG_W   = 4;
    localparam int BEN_W   = 5;
    localparam int TAG_W   = ROW_W + SEG_W;
    localparam int BEN_MAX = (1 << BEN_W) - 1;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [TAG_W-1:0] tag;
        logic [BEN_W-1:0] benefit;
    } entry_t;

    function automatic logic [BEN_W-1:0] ben_sat_inc(input logic [BEN_W-1:0] b);
        return (b == BEN_W'(BEN_MAX)) ? b : b + 1'b1;
    endfunction
endpackage

// File: rtl/seg_tag_entry.sv
module seg_tag_entry
    import seg_tag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             wr_i,
    input  logic             upd_i,
    input  logic             upd_dirty_i,
    input  logic [BEN_W-1:0] upd_ben_i,
    input  logic             ins_i,
    input  logic [TAG_W-1:0] ins_tag_i,
    input  logic             inv_i,
    output entry_t           ent_o
);
    entry_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        // lowest precedence first, later writes override
        if (hit_i) begin
            ent_d.benefit = ben_sat_inc(ent_q.benefit);
            if (wr_i) ent_d.dirty = 1'b1;
        end
        if (upd_i) begin
            ent_d.dirty   = upd_dirty_i;
            ent_d.benefit = upd_ben_i;
        end
        if (ins_i) begin
            ent_d.valid   = 1'b1;
            ent_d.dirty   = 1'b0;
            ent_d.tag     = ins_tag_i;
            ent_d.benefit = BEN_W'(1);
        end
        if (inv_i) ent_d.valid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign ent_o = ent_q;
endmodule

// File: rtl/seg_tag_match.sv
module seg_tag_match
    import seg_tag_pkg::*;
#(
    parameter int ENTRIES = 512,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]              key_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              idx_o
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (tags_i[g] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
        hit_o = |match;
    end
endmodule

// File: rtl/seg_tag_store.sv
module seg_tag_store
    import seg_tag_pkg::*;
#(
    parameter int ENTRIES = 512,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_req,
    input  logic [ROW_W-1:0]         lk_row,
    input  logic [SEG_W-1:0]         lk_seg,
    input  logic                     lk_write,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [IDX_W-1:0]         rsp_idx,
    input  logic                     ins_req,
    input  logic [IDX_W-1:0]         ins_idx,
    input  logic [ROW_W-1:0]         ins_row,
    input  logic [SEG_W-1:0]         ins_seg,
    input  logic                     upd_req,
    input  logic [IDX_W-1:0]         upd_idx,
    input  logic                     upd_dirty,
    input  logic [BEN_W-1:0]         upd_benefit,
    input  logic                     inv_req,
    input  logic [IDX_W-1:0]         inv_idx,
    output logic                     inv_rsp_valid,
    output logic                     inv_rsp_dirty,
    output logic [ENTRIES*BEN_W-1:0] benefit_all
);
    typedef struct packed {
        logic             rsp_valid;
        logic             rsp_hit;
        logic [IDX_W-1:0] rsp_idx;
        logic             inv_valid;
        logic             inv_dirty;
    } resp_t;

    entry_t                         ent [ENTRIES];
    logic [ENTRIES-1:0]             valid_vec;
    logic [ENTRIES-1:0]             dirty_vec;
    logic [ENTRIES-1:0][TAG_W-1:0]  tag_vec;
    logic                           hit_c;
    logic [IDX_W-1:0]               hit_idx_c;
    resp_t                          resp_d, resp_q;

    seg_tag_match #(.ENTRIES(ENTRIES)) u_match (
        .valid_i (valid_vec),
        .tags_i  (tag_vec),
        .key_i   ({lk_row, lk_seg}),
        .hit_o   (hit_c),
        .idx_o   (hit_idx_c)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        seg_tag_entry u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .hit_i       (lk_req && hit_c && (hit_idx_c == IDX_W'(g))),
            .wr_i        (lk_write),
            .upd_i       (upd_req && (upd_idx == IDX_W'(g))),
            .upd_dirty_i (upd_dirty),
            .upd_ben_i   (upd_benefit),
            .ins_i       (ins_req && (ins_idx == IDX_W'(g))),
            .ins_tag_i   ({ins_row, ins_seg}),
            .inv_i       (inv_req && (inv_idx == IDX_W'(g))),
            .ent_o       (ent[g])
        );
        assign valid_vec[g]                 = ent[g].valid;
        assign dirty_vec[g]                 = ent[g].dirty;
        assign tag_vec[g]                   = ent[g].tag;
        assign benefit_all[g*BEN_W +: BEN_W] = ent[g].benefit;
    end

    always_comb begin
        resp_d           = '0;
        resp_d.rsp_valid = lk_req;
        resp_d.rsp_hit   = lk_req && hit_c;
        resp_d.rsp_idx   = (lk_req && hit_c) ? hit_idx_c : '0;
        resp_d.inv_valid = inv_req;
        resp_d.inv_dirty = inv_req && dirty_vec[inv_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign rsp_valid     = resp_q.rsp_valid;
    assign rsp_hit       = resp_q.rsp_hit;
    assign rsp_idx       = resp_q.rsp_idx;
    assign inv_rsp_valid = resp_q.inv_valid;
    assign inv_rsp_dirty = resp_q.inv_dirty;
endmodule

// File: rtl/seg_tag_store_chk.sv
module seg_tag_store_chk
    import seg_tag_pkg::*;
#(
    parameter int ENTRIES = 512,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     lk_req,
    input logic                     rsp_valid,
    input logic                     rsp_hit,
    input logic [IDX_W-1:0]         rsp_idx,
    input logic                     ins_req,
    input logic [IDX_W-1:0]         ins_idx,
    input logic                     upd_req,
    input logic                     inv_req,
    input logic                     inv_rsp_valid,
    input logic [ENTRIES*BEN_W-1:0] benefit_all
);
    function automatic logic [BEN_W-1:0] ben_at(input logic [ENTRIES*BEN_W-1:0] v,
                                                input logic [IDX_W-1:0] i);
        return v[i*BEN_W +: BEN_W];
    endfunction

    p_rsp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(lk_req));

    p_hit_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    p_hit_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !upd_req && !ins_req && !inv_req) |=>
        (!rsp_hit || ben_at(benefit_all, rsp_idx) ==
                     ben_sat_inc(ben_at($past(benefit_all), rsp_idx))));

    p_ins_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !inv_req) |=> ben_at(benefit_all, $past(ins_idx)) == BEN_W'(1));

    p_inv_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_rsp_valid == $past(inv_req));
endmodule

bind seg_tag_store seg_tag_store_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_req        (lk_req),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_idx       (rsp_idx),
    .ins_req       (ins_req),
    .ins_idx       (ins_idx),
    .upd_req       (upd_req),
    .inv_req       (inv_req),
    .inv_rsp_valid (inv_rsp_valid),
    .benefit_all   (benefit_all)
);

// File: tb/seg_tag_store_bench.sv
`timescale 1ns/1ps
module seg_tag_store_bench;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam int BW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lk_req, lk_write;
    logic [14:0]   lk_row;
    logic [3:0]    lk_seg;
    logic          rsp_valid, rsp_hit;
    logic [IW-1:0] rsp_idx;
    logic          ins_req;
    logic [IW-1:0] ins_idx;
    logic [14:0]   ins_row;
    logic [3:0]    ins_seg;
    logic          upd_req, upd_dirty;
    logic [IW-1:0] upd_idx;
    logic [4:0]    upd_benefit;
    logic          inv_req;
    logic [IW-1:0] inv_idx;
    logic          inv_rsp_valid, inv_rsp_dirty;
    logic [N*BW-1:0] benefit_all;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    seg_tag_store #(.ENTRIES(N)) u_seg_tag_store (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ben(input int i);
        return int'(benefit_all[i*BW +: BW]);
    endfunction

    task automatic clr();
        lk_req = 0; lk_write = 0; lk_row = '0; lk_seg = '0;
        ins_req = 0; ins_idx = '0; ins_row = '0; ins_seg = '0;
        upd_req = 0; upd_idx = '0; upd_dirty = 0; upd_benefit = '0;
        inv_req = 0; inv_idx = '0;
    endtask

    task automatic step();
        @(posedge clk); #1; clr();
    endtask

    task automatic set_look(input int row, input int seg, input bit wr);
        lk_req = 1; lk_row = 15'(row); lk_seg = 4'(seg); lk_write = wr;
    endtask
    task automatic set_ins(input int idx, input int row, input int seg);
        ins_req = 1; ins_idx = IW'(idx); ins_row = 15'(row); ins_seg = 4'(seg);
    endtask
    task automatic set_upd(input int idx, input bit d, input int b);
        upd_req = 1; upd_idx = IW'(idx); upd_dirty = d; upd_benefit = 5'(b);
    endtask
    task automatic set_inv(input int idx);
        inv_req = 1; inv_idx = IW'(idx);
    endtask

    // lookup, then check validity, hit and (when a hit is expected) index
    task automatic look(input string req, input int row, input int seg, input bit wr,
                        input bit exp_hit, input int exp_idx);
        set_look(row, seg, wr); step();
        chk({req, " rsp_valid"}, rsp_valid, 1);
        chk({req, " hit"}, rsp_hit, exp_hit);
        if (exp_hit) chk({req, " idx"}, rsp_idx, exp_idx);
    endtask

    task automatic inval(input string req, input int idx, input bit exp_dirty);
        set_inv(idx); step();
        chk({req, " inv_rsp_valid"}, inv_rsp_valid, 1);
        chk({req, " inv dirty"}, inv_rsp_dirty, exp_dirty);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clr();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        for (int i = 0; i < N; i++) chk("R1 score", ben(i), 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 inv_rsp_valid", inv_rsp_valid, 0);
        look("R1", 0, 0, 0, 0, 0);
        step();
        chk("R2 rsp_valid drops", rsp_valid, 0);

        // R6 R10 fill every slot
        for (int i = 0; i < N; i++) begin
            set_ins(i, i*37 + 5, i); step();
            chk("R6 R10 score after insert", ben(i), 1);
        end
        // R2 R3 R4 hit sweep
        for (int i = 0; i < N; i++) begin
            look("R2 R3", i*37 + 5, i, 0, 1, i);
            chk("R4 score incr", ben(i), 2);
            chk("R4 neighbour unchanged", ben((i+1) % N), (i+1 < N) ? 1 : 2);
        end
        // R2 miss sweep: wrong row, wrong segment
        for (int i = 0; i < N; i++) begin
            look("R2 row miss", i*37 + 6, i, 0, 0, 0);
            look("R2 seg miss", i*37 + 5, (i+1) % 16, 0, 0, 0);
        end
        // R5 write hits on even slots
        for (int i = 0; i < N; i += 2) look("R5 write hit", i*37 + 5, i, 1, 1, i);
        // R5 R8 drain
        for (int i = 0; i < N; i++) begin
            inval("R5 R8", i, (i % 2) == 0);
            look("R8 after inval", i*37 + 5, i, 0, 0, 0);
        end

        // R4 saturation
        set_ins(3, 100, 2); step();
        for (int k = 1; k <= 40; k++) begin
            look("R4 sat", 100, 2, 0, 1, 3);
            chk("R4 sat score", ben(3), (1 + k > 31) ? 31 : 1 + k);
        end
        // R7 update
        set_upd(3, 1, 17); step();
        chk("R7 score", ben(3), 17);
        inval("R7 dirty set", 3, 1);
        set_ins(4, 101, 3); step();
        look("R5 write", 101, 3, 1, 1, 4);
        set_upd(4, 0, 9); step();
        chk("R7 score", ben(4), 9);
        inval("R7 dirty clear", 4, 0);

        // R3 duplicate tags: lowest index wins
        set_ins(5, 200, 1); step();
        set_ins(2, 200, 1); step();
        look("R3 dup", 200, 1, 0, 1, 2);
        inval("R3 dup inv", 2, 0);
        look("R3 dup remain", 200, 1, 0, 1, 5);

        // R9 insert and invalidate same slot same cycle
        set_ins(6, 300, 3); set_inv(6); step();
        look("R9 inv over ins", 300, 3, 0, 0, 0);
        // R9 lookup sees pre-cycle contents
        set_look(400, 4, 0); set_ins(7, 400, 4); step();
        chk("R9 pre-cycle miss", rsp_hit, 0);
        look("R9 then hit", 400, 4, 0, 1, 7);
        chk("R9 score", ben(7), 2);
        // R9 update over hit
        set_look(400, 4, 1); set_upd(7, 0, 10); step();
        chk("R9 upd over hit hit", rsp_hit, 1);
        chk("R9 upd over hit score", ben(7), 10);
        inval("R9 upd over hit dirty", 7, 0);
        // R9 insert over update
        set_ins(0, 500, 5); set_upd(0, 1, 20); step();
        chk("R9 ins over upd score", ben(0), 1);
        inval("R9 ins over upd dirty", 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule